// File: doc/BRIEF.md
# Bulk Transfer Descriptor Retry Updater

This block sits beside the host scheduler of a USB host controller. Each time a bulk transaction attempt finishes, the scheduler presents the descriptor's current control fields together with a one-cycle outcome strobe. One clock later the block returns the rewritten fields and a one-cycle update pulse. The fields are the valid bit, the error budget, the NAK budget, the token and the byte count. The update also raises a retire or halt flag when the descriptor must leave the schedule.

Two budgets are kept apart. The error budget counts down on failed attempts, and a failure with no budget left halts the descriptor. The NAK budget counts down on NAK handshakes and reloads from a programmable value whenever an attempt is acknowledged. A reload value of zero turns the NAK limit off. The block also swaps the OUT token for PING while an OUT endpoint keeps answering NAK. A separate combinational path turns a CPU byte address into an internal memory word address.

Top module: `bulk_td_updater`

## Requirements
- R1: After reset every registered output is zero. An outcome strobe (`ev_stb`) yields `upd_stb` high for exactly one cycle, on the next clock edge, and the updated fields appear at that edge. All registered outputs then hold until the next strobe, whatever the field inputs do.
- R2: Outcome code 00 (ACK) loads the NAK budget from the reload value and takes the byte count from `ev_bytes`. The error budget and the valid bit pass through, and neither flag is raised.
- R3: Outcome code 01 (NAK) with a nonzero reload value lowers the NAK budget by one and keeps the byte count. A budget that reaches zero, or that was already zero, clears the valid bit and raises `out_retire`.
- R4: A NAK with reload value zero leaves the NAK budget and the valid bit unchanged and never raises `out_retire`.
- R5: Outcome code 10 (error) with a nonzero error budget lowers that budget by one and keeps the valid bit. A budget of 3 therefore gives three retries before a halt.
- R6: An error with an error budget of 00 clears the valid bit, keeps the budget at 00 and raises `out_halt`.
- R7: The token encoding is 00 OUT, 01 IN, 10 SETUP and 11 PING. A NAK on an OUT token returns PING. An ACK on a PING token returns OUT. Every other combination keeps the token.
- R8: Outcome code 11 is reserved. Every field passes through unchanged and no flag is raised.
- R9: The memory address is (CPU address − 0x400) / 8 and is produced combinationally.
- R10: A CPU address below 0x400, or one whose low three bits are not zero, raises `addr_err` and gives a memory address of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Current valid bit |
| in_cerr | input | 2 | Current error budget |
| in_nak | input | 4 | Current NAK budget |
| in_rl | input | 4 | NAK reload value, 0 turns the NAK limit off |
| in_tok | input | 2 | Current token |
| in_bytes | input | 15 | Current byte count |
| ev_stb | input | 1 | Outcome strobe, one cycle |
| ev_code | input | 2 | Outcome: 00 ACK, 01 NAK, 10 error, 11 reserved |
| ev_bytes | input | 15 | Bytes moved by the acknowledged attempt |
| upd_stb | output | 1 | Updated fields are valid (one cycle) |
| out_vld | output | 1 | Updated valid bit |
| out_cerr | output | 2 | Updated error budget |
| out_nak | output | 4 | Updated NAK budget |
| out_tok | output | 2 | Updated token |
| out_bytes | output | 15 | Updated byte count |
| out_retire | output | 1 | NAK budget ran out |
| out_halt | output | 1 | Error with no retries left |
| cpu_addr | input | 16 | CPU byte address |
| mem_addr | output | 16 | Internal memory word address |
| addr_err | output | 1 | CPU address out of range or misaligned |

## Verification
A wrong budget decision is visible at the ports one edge after the strobe. A bad decrement, a missed reload or a wrapped error budget shows as a wrong value on `out_nak` or `out_cerr`. It also shows as a valid bit that stays set, or as a retire or halt flag that is missing or spurious, all in the same update. Token errors show in the same update as PING held after an ACK, or as OUT kept after a NAK. Because the outputs are meant to hold, a register that reloads outside a strobe shows up in the next idle cycle. Address faults are combinational and visible at once.

// File: rtl/bulk_td_pkg.sv
package bulk_td_pkg;
   typedef enum logic [1:0] {
      OC_ACK  = 2'b00,
      OC_NAK  = 2'b01,
      OC_ERR  = 2'b10,
      OC_RSVD = 2'b11
   } outcome_e;

   typedef enum logic [1:0] {
      TK_OUT   = 2'b00,
      TK_IN    = 2'b01,
      TK_SETUP = 2'b10,
      TK_PING  = 2'b11
   } token_e;
endpackage

// File: rtl/td_nak_budget.sv
module td_nak_budget #(
   parameter int NAK_W = 4
) (
   input  logic             is_ack,
   input  logic             is_nak,
   input  logic [NAK_W-1:0] nak_in,
   input  logic [NAK_W-1:0] rl_in,
   output logic [NAK_W-1:0] nak_out,
   output logic             exhausted
);
   localparam logic [NAK_W-1:0] ONE = NAK_W'(1);

   logic limit_on;
   assign limit_on = (rl_in != '0);

   always_comb begin
      nak_out   = nak_in;
      exhausted = 1'b0;
      if (is_ack) begin
         nak_out = rl_in;
      end else if (is_nak && limit_on) begin
         nak_out   = (nak_in == '0) ? '0 : nak_in - ONE;
         exhausted = (nak_in <= ONE);
      end
   end

   always_comb begin
      if (exhausted) a_r3_exhaust_zero : assert (nak_out == '0);
   end
endmodule

// File: rtl/td_err_budget.sv
module td_err_budget #(
   parameter int CERR_W = 2
) (
   input  logic              is_err,
   input  logic [CERR_W-1:0] cerr_in,
   output logic [CERR_W-1:0] cerr_out,
   output logic              halt
);
   always_comb begin
      cerr_out = cerr_in;
      halt     = 1'b0;
      if (is_err) begin
         if (cerr_in == '0) halt = 1'b1;
         else               cerr_out = cerr_in - CERR_W'(1);
      end
   end

   always_comb begin
      if (halt) a_r6_no_wrap : assert (cerr_out == '0);
   end
endmodule

// File: rtl/td_addr_xlate.sv
module td_addr_xlate #(
   parameter int ADDR_W = 16,
   parameter int BASE   = 'h400,
   parameter int SHIFT  = 3
) (
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              addr_err
);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

   generate
      if (SHIFT < 1 || SHIFT >= ADDR_W) begin : g_bad_shift
         $error("td_addr_xlate: SHIFT out of range");
      end
   endgenerate

   logic [ADDR_W-1:0] offset;
   logic below, misaligned;

   assign offset     = cpu_addr - BASE_V;
   assign below      = (cpu_addr < BASE_V);
   assign misaligned = |cpu_addr[SHIFT-1:0];
   assign addr_err   = below | misaligned;
   assign mem_addr   = addr_err ? '0 : (offset >> SHIFT);

   always_comb begin
      if (addr_err) a_r10_err_zero : assert (mem_addr == '0);
   end
endmodule

// File: rtl/bulk_td_updater.sv
module bulk_td_updater
   import bulk_td_pkg::*;
#(
   parameter int  CERR_W    = 2,
   parameter int  NAK_W     = 4,
   parameter int  BYTE_W    = 15,
   parameter int  ADDR_W    = 16,
   parameter int  ADDR_BASE = 'h400,
   parameter int  ADDR_SHIFT = 3,
   parameter bit  PING_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [CERR_W-1:0] in_cerr,
   input  logic [NAK_W-1:0]  in_nak,
   input  logic [NAK_W-1:0]  in_rl,
   input  logic [1:0]        in_tok,
   input  logic [BYTE_W-1:0] in_bytes,
   input  logic              ev_stb,
   input  logic [1:0]        ev_code,
   input  logic [BYTE_W-1:0] ev_bytes,
   output logic              upd_stb,
   output logic              out_vld,
   output logic [CERR_W-1:0] out_cerr,
   output logic [NAK_W-1:0]  out_nak,
   output logic [1:0]        out_tok,
   output logic [BYTE_W-1:0] out_bytes,
   output logic              out_retire,
   output logic              out_halt,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              addr_err
);
   generate
      if (CERR_W < 1 || NAK_W < 1 || BYTE_W < 1) begin : g_bad_width
         $error("bulk_td_updater: field widths must be positive");
      end
   endgenerate

   logic is_ack, is_nak, is_err;
   assign is_ack = (ev_code == OC_ACK);
   assign is_nak = (ev_code == OC_NAK);
   assign is_err = (ev_code == OC_ERR);

   logic [NAK_W-1:0]  nak_nx;
   logic [CERR_W-1:0] cerr_nx;
   logic              exhausted, halt_nx;
   logic [1:0]        tok_nx;

   td_nak_budget #(.NAK_W(NAK_W)) u_nak (
      .is_ack(is_ack), .is_nak(is_nak), .nak_in(in_nak), .rl_in(in_rl),
      .nak_out(nak_nx), .exhausted(exhausted)
   );

   td_err_budget #(.CERR_W(CERR_W)) u_err (
      .is_err(is_err), .cerr_in(in_cerr), .cerr_out(cerr_nx), .halt(halt_nx)
   );

   td_addr_xlate #(.ADDR_W(ADDR_W), .BASE(ADDR_BASE), .SHIFT(ADDR_SHIFT)) u_addr (
      .cpu_addr(cpu_addr), .mem_addr(mem_addr), .addr_err(addr_err)
   );

   generate
      if (PING_EN) begin : g_ping
         always_comb begin
            tok_nx = in_tok;
            if (is_nak && in_tok == TK_OUT)       tok_nx = TK_PING;
            else if (is_ack && in_tok == TK_PING) tok_nx = TK_OUT;
         end
      end else begin : g_no_ping
         assign tok_nx = in_tok;
      end
   endgenerate

   logic              vld_nx;
   logic [BYTE_W-1:0] bytes_nx;
   assign vld_nx   = in_vld & ~exhausted & ~halt_nx;
   assign bytes_nx = is_ack ? ev_bytes : in_bytes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_stb    <= 1'b0;
         out_vld    <= 1'b0;
         out_cerr   <= '0;
         out_nak    <= '0;
         out_tok    <= '0;
         out_bytes  <= '0;
         out_retire <= 1'b0;
         out_halt   <= 1'b0;
      end else begin
         upd_stb <= ev_stb;
         if (ev_stb) begin
            out_vld    <= vld_nx;
            out_cerr   <= cerr_nx;
            out_nak    <= nak_nx;
            out_tok    <= tok_nx;
            out_bytes  <= bytes_nx;
            out_retire <= exhausted;
            out_halt   <= halt_nx;
         end
      end
   end

   a_r1_one_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      ev_stb |=> upd_stb);
   a_r1_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !ev_stb |=> (!upd_stb && $stable(out_nak) && $stable(out_vld) && $stable(out_cerr)));
   a_r2_reload : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stb && ev_code == OC_ACK) |=> (out_nak == $past(in_rl) && !out_retire && !out_halt));
   a_r3_retire_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && out_retire) |-> !out_vld);
   a_r4_limit_off : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stb && ev_code == OC_NAK && in_rl == '0) |=> (out_nak == $past(in_nak) && !out_retire));
   a_r6_halt : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stb && ev_code == OC_ERR && in_cerr == '0) |=> (out_halt && !out_vld));
   a_r8_reserved : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stb && ev_code == OC_RSVD) |=> (!out_halt && !out_retire && out_tok == $past(in_tok)));
endmodule

// File: tb/bulk_td_updater_tb_top.sv
module bulk_td_updater_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [1:0]  in_cerr = '0;
   logic [3:0]  in_nak = '0, in_rl = '0;
   logic [1:0]  in_tok = '0;
   logic [14:0] in_bytes = '0;
   logic        ev_stb = 1'b0;
   logic [1:0]  ev_code = '0;
   logic [14:0] ev_bytes = '0;
   logic        upd_stb, out_vld, out_retire, out_halt, addr_err;
   logic [1:0]  out_cerr, out_tok;
   logic [3:0]  out_nak;
   logic [14:0] out_bytes;
   logic [15:0] cpu_addr = '0, mem_addr;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bulk_td_updater dut_i (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_cerr(in_cerr), .in_nak(in_nak),
      .in_rl(in_rl), .in_tok(in_tok), .in_bytes(in_bytes), .ev_stb(ev_stb),
      .ev_code(ev_code), .ev_bytes(ev_bytes), .upd_stb(upd_stb), .out_vld(out_vld),
      .out_cerr(out_cerr), .out_nak(out_nak), .out_tok(out_tok), .out_bytes(out_bytes),
      .out_retire(out_retire), .out_halt(out_halt), .cpu_addr(cpu_addr),
      .mem_addr(mem_addr), .addr_err(addr_err)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic void model(
      input logic v, input logic [1:0] ce, input logic [3:0] nk, input logic [3:0] rl,
      input logic [1:0] tk, input logic [14:0] by, input logic [1:0] code,
      input logic [14:0] eb,
      output logic ev, output logic [1:0] ece, output logic [3:0] enk,
      output logic [1:0] etk, output logic [14:0] eby, output logic eret,
      output logic ehalt);
      ev = v; ece = ce; enk = nk; etk = tk; eby = by; eret = 0; ehalt = 0;
      case (code)
         2'b00: begin enk = rl; eby = eb; if (tk == 2'b11) etk = 2'b00; end
         2'b01: begin
            if (tk == 2'b00) etk = 2'b11;
            if (rl != 0) begin
               enk = (nk == 0) ? 4'd0 : nk - 4'd1;
               if (nk <= 1) begin eret = 1; ev = 0; end
            end
         end
         2'b10: begin
            if (ce == 0) begin ehalt = 1; ev = 0; end
            else ece = ce - 2'd1;
         end
         default: ;
      endcase
   endfunction

   function automatic string req_of(input logic [1:0] code, input logic [3:0] rl,
                                    input logic [1:0] ce);
      case (code)
         2'b00: return "R2";
         2'b01: return (rl == 0) ? "R4" : "R3";
         2'b10: return (ce == 0) ? "R6" : "R5";
         default: return "R8";
      endcase
   endfunction

   task automatic txn(input logic v, input logic [1:0] ce, input logic [3:0] nk,
                      input logic [3:0] rl, input logic [1:0] tk, input logic [14:0] by,
                      input logic [1:0] code, input logic [14:0] eb, input bit hold);
      logic ev, eret, ehalt;
      logic [1:0] ece, etk;
      logic [3:0] enk;
      logic [14:0] eby;
      string r;
      model(v, ce, nk, rl, tk, by, code, eb, ev, ece, enk, etk, eby, eret, ehalt);
      r = req_of(code, rl, ce);
      @(negedge clk);
      in_vld = v; in_cerr = ce; in_nak = nk; in_rl = rl; in_tok = tk; in_bytes = by;
      ev_code = code; ev_bytes = eb; ev_stb = 1'b1;
      @(negedge clk);
      ev_stb = 1'b0;
      chk(32'(upd_stb), 1, "R1 upd_stb pulse");
      chk(32'(out_vld), 32'(ev), {r, " vld"});
      chk(32'(out_cerr), 32'(ece), {r, " cerr"});
      chk(32'(out_nak), 32'(enk), {r, " nak"});
      chk(32'(out_bytes), 32'(eby), {r, " bytes"});
      chk(32'(out_retire), 32'(eret), {r, " retire"});
      chk(32'(out_halt), 32'(ehalt), {r, " halt"});
      chk(32'(out_tok), 32'(etk), "R7 token");
      if (hold) begin
         in_vld = ~v; in_cerr = ~ce; in_nak = ~nk; in_rl = ~rl; in_tok = ~tk;
         in_bytes = ~by; ev_code = ~code; ev_bytes = ~eb;
         @(negedge clk);
         chk(32'(upd_stb), 0, "R1 pulse ends");
         chk({out_vld, out_cerr, out_nak, out_tok, out_bytes, out_retire, out_halt},
             {ev, ece, enk, etk, eby, eret, ehalt}, "R1 hold");
      end
   endtask

   task automatic addr_chk(input logic [15:0] a);
      logic err;
      logic [15:0] exp;
      err = (a < 16'h400) || (a[2:0] != 0);
      exp = err ? 16'h0 : ((a - 16'h400) >> 3);
      cpu_addr = a;
      #1;
      chk(32'(addr_err), 32'(err), "R10 addr_err");
      chk(32'(mem_addr), 32'(exp), err ? "R10 mem zero" : "R9 mem_addr");
   endtask

   initial begin
      #40000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'd1761);
      repeat (3) @(negedge clk);
      chk({upd_stb, out_vld, out_cerr, out_nak, out_tok, out_bytes, out_retire, out_halt},
          0, "R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      // R2 ack reload, PING back to OUT
      txn(1, 2'd3, 4'd2, 4'd9, 2'b11, 15'd0, 2'b00, 15'd512, 1);
      // R3 nak countdown then exhaustion, OUT becomes PING
      txn(1, 2'd3, 4'd3, 4'd5, 2'b00, 15'd7, 2'b01, 15'd99, 0);
      txn(1, 2'd3, 4'd1, 4'd5, 2'b11, 15'd7, 2'b01, 15'd99, 1);
      txn(1, 2'd3, 4'd0, 4'd5, 2'b01, 15'd7, 2'b01, 15'd99, 0);
      // R4 limit off
      txn(1, 2'd1, 4'd1, 4'd0, 2'b00, 15'd3, 2'b01, 15'd0, 0);
      txn(1, 2'd1, 4'd0, 4'd0, 2'b01, 15'd3, 2'b01, 15'd0, 0);
      // R5/R6 three retries then halt
      txn(1, 2'd3, 4'd4, 4'd4, 2'b10, 15'd0, 2'b10, 15'd0, 0);
      txn(1, 2'd2, 4'd4, 4'd4, 2'b10, 15'd0, 2'b10, 15'd0, 0);
      txn(1, 2'd1, 4'd4, 4'd4, 2'b10, 15'd0, 2'b10, 15'd0, 0);
      txn(1, 2'd0, 4'd4, 4'd4, 2'b10, 15'd0, 2'b10, 15'd0, 1);
      // R8 reserved code
      txn(1, 2'd2, 4'd6, 4'd7, 2'b00, 15'h7fff, 2'b11, 15'd1, 1);
      for (int i = 0; i < 400; i++) begin
         txn(1'($urandom), 2'($urandom), 4'($urandom), 4'($urandom), 2'($urandom),
             15'($urandom), 2'($urandom), 15'($urandom), (i % 7) == 0);
      end
      // R9 / R10 addresses
      addr_chk(16'h0400); addr_chk(16'h0408); addr_chk(16'h03F8); addr_chk(16'h0404);
      addr_chk(16'h0000); addr_chk(16'hFFF8); addr_chk(16'hFFFF);
      for (int i = 0; i < 60; i++) addr_chk(16'($urandom) & ((i % 2) ? 16'hFFF8 : 16'hFFFF));
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule